// File: doc/BRIEF.md
# Page Write Load Controller with Polling

This block models the write side of a byte-wide nonvolatile memory in synchronous logic. A host issues byte-load strobes, each with an address and a data byte. The block collects them into a one-page buffer, and each load restarts a byte-load window. When the window expires with no further load, the block starts a self-timed programming interval. During that interval `busy` is high. At the end of the interval the collected bytes are written into the storage array.

While programming runs, reads return polling status instead of plain array data. Bit 7 of a read from the most recently loaded address is the inverse of the data written there. Bit 6 flips on every read. The host can use either bit to detect when the write has finished. The storage array is a plain register model. The window length and the programming time are parameters counted in clock cycles.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset, `busy`, `page_err` and `rd_data` are 0 and every array byte reads as 0x00.
- R2: One write operation is either a single byte load or a burst of loads into the same page, up to the page size. The loaded bytes reach the array only when the programming interval ends.
- R3: A load is accepted into the current burst if it arrives at most WIN_CYCLES clock edges after the previous accepted load. If WIN_CYCLES edges pass with no accepted load, `busy` rises after the WIN_CYCLES-th edge.
- R4: The page of an address is its bits above bit PAGE_W-1. A load during a burst whose page differs from the first load's page is ignored, and `page_err` is driven high for exactly one cycle.
- R5: `busy` stays high for exactly PROG_CYCLES clock cycles and then returns to 0.
- R6: While `busy` is high, a read of the last loaded address returns the complement of that byte's bit 7. After programming ends, bit 7 is the true stored value.
- R7: While `busy` is high, bit 6 of the read data is 0 on the first read of each programming interval and inverts on every later read.
- R8: Loads presented while `busy` is high are ignored.
- R9: Bytes of the page that were not loaded in the burst keep their previous contents.
- R10: Read data appears one cycle after `rd_en`. Outside programming it is the array byte. During programming, the bits other than bit 6 (and other than bit 7 of the last loaded address) come from the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Byte-load strobe |
| ld_addr | input | ADDR_W | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, registered |
| busy | output | 1 | Programming interval running |
| page_err | output | 1 | One-cycle pulse when a load from a different page is rejected |

## Verification
The bench probes the edges of the byte-load window: a load exactly WIN_CYCLES edges after the last one must join the burst, and a load one edge later must land in a busy interval. A window off by one would either split the burst or swallow the late load. Polling reads alternate between the last loaded address and another address. This exposes a toggle that does not restart at 0, and a bit-7 inversion applied to every address instead of only the last one. Cross-page loads, loads made while busy, and unloaded neighbours in the page are read back afterwards. A design that commits the whole buffer or accepts a stray load would show a changed byte there.

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 6,
  parameter int WIN_CYCLES  = 8,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HI_W    = ADDR_W - PAGE_W;
  localparam int WC_W    = $clog2(WIN_CYCLES + 1);
  localparam int PC_W    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t               st;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE_SZ];
  logic [PAGE_SZ-1:0] vld;
  logic [HI_W-1:0]   pg;
  logic [ADDR_W-1:0] last_a;
  logic [7:0]        last_d;
  logic [WC_W-1:0]   wcnt;
  logic [PC_W-1:0]   pcnt;
  logic              tog;

  wire [HI_W-1:0]   ld_pg   = ld_addr[ADDR_W-1:PAGE_W];
  wire [PAGE_W-1:0] ld_off  = ld_addr[PAGE_W-1:0];
  wire              same_pg = (ld_pg == pg);
  wire              take    = ld_en && ((st == S_IDLE) || (st == S_LOAD && same_pg));
  wire [7:0]        rd_mem  = mem[rd_addr];

  assign busy = (st == S_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vld      <= '0;
      pg       <= '0;
      last_a   <= '0;
      last_d   <= '0;
      wcnt     <= '0;
      pcnt     <= '0;
      tog      <= 1'b0;
      rd_data  <= '0;
      page_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_SZ; i++) pbuf[i] <= '0;
    end else begin
      page_err <= ld_en && (st == S_LOAD) && !same_pg;
      if (take) begin
        pbuf[ld_off] <= ld_data;
        vld[ld_off]  <= 1'b1;
        pg           <= ld_pg;
        last_a       <= ld_addr;
        last_d       <= ld_data;
        wcnt         <= '0;
        st           <= S_LOAD;
      end else begin
        case (st)
          S_LOAD: begin
            if (wcnt == WC_W'(WIN_CYCLES - 1)) begin
              st   <= S_PROG;
              pcnt <= '0;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          S_PROG: begin
            if (pcnt == PC_W'(PROG_CYCLES - 1)) begin
              for (int i = 0; i < PAGE_SZ; i++)
                if (vld[i]) mem[{pg, PAGE_W'(i)}] <= pbuf[i];
              vld <= '0;
              st  <= S_IDLE;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (rd_en) begin
        if (busy) begin
          rd_data <= {(rd_addr == last_a) ? ~last_d[7] : rd_mem[7], tog, rd_mem[5:0]};
          tog     <= ~tog;
        end else begin
          rd_data <= rd_mem;
        end
      end
      if (st == S_LOAD && !take && wcnt == WC_W'(WIN_CYCLES - 1)) tog <= 1'b0;
    end
  end

  a_r4_err_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> $past(st == S_LOAD && ld_en));

  a_r3_prog_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st == S_LOAD && !ld_en));

  a_r7_poll_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && $past(busy && rd_en)) |=> (rd_data[6] != $past(rd_data[6])));

  a_r8_no_err_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_en) |=> !page_err);

  a_r5_busy_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (st == S_IDLE));
endmodule

// File: tb/page_prog_ctrl_tb_top.sv
module page_prog_ctrl_tb_top;
  localparam int AW = 9, WIN = 8, PROG = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [7:0] ld_data = '0, rd_data;
  logic busy, page_err;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  page_prog_ctrl #(.ADDR_W(AW), .PAGE_W(6), .WIN_CYCLES(WIN), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .page_err(page_err));

  // {idle cycles before load, address, data}: one burst in page 2
  localparam logic [20:0] VEC [4] = '{
    {4'd0, 9'h085, 8'h3C},
    {4'd3, 9'h0A0, 8'hC1},
    {4'd7, 9'h0BF, 8'h7E},
    {4'd0, 9'h090, 8'h01}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(logic [AW-1:0] a, logic [7:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 page_err", {7'd0, page_err}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    rd(9'h1FF, r); check("R1 array", r, 8'h00);

    // R2/R3 burst with gaps up to the full window
    for (int i = 0; i < 4; i++) begin
      repeat (VEC[i][20:17]) @(negedge clk);
      load(VEC[i][16:8], VEC[i][7:0]);
    end
    repeat (WIN - 1) @(negedge clk);
    check("R3 not yet busy", {7'd0, busy}, 8'h00);
    @(negedge clk);
    check("R3 busy after window", {7'd0, busy}, 8'h01);
    rd(9'h090, r); check("R6 R7 poll last first", r, 8'h80);
    rd(9'h090, r); check("R6 R7 poll last second", r, 8'hC0);
    rd(9'h085, r); check("R10 poll other addr", r, 8'h00);
    load(9'h1F0, 8'h55);
    wait_idle();
    rd(9'h090, r); check("R6 true bit7 after", r, 8'h01);
    for (int i = 0; i < 3; i++) begin
      rd(VEC[i][16:8], r); check("R2 burst byte", r, VEC[i][7:0]);
    end
    rd(9'h086, r); check("R9 unloaded byte", r, 8'h00);
    rd(9'h1F0, r); check("R8 load while busy", r, 8'h00);

    // single byte op and busy length
    load(9'h1F0, 8'h55);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (busy) cnt++;
      else if (cnt > 0) break;
    end
    check("R5 busy length", 8'(cnt), 8'(PROG));
    rd(9'h1F0, r); check("R2 single byte", r, 8'h55);

    // page mismatch
    load(9'h040, 8'h11);
    load(9'h0C0, 8'h22);
    check("R4 err pulse", {7'd0, page_err}, 8'h01);
    @(negedge clk);
    check("R4 err one cycle", {7'd0, page_err}, 8'h00);
    while (!busy) @(negedge clk);
    wait_idle();
    rd(9'h0C0, r); check("R4 mismatched ignored", r, 8'h00);
    rd(9'h040, r); check("R4 first page written", r, 8'h11);

    // gap one longer than the window
    load(9'h100, 8'hAA);
    repeat (WIN) @(negedge clk);
    check("R3 late load sees busy", {7'd0, busy}, 8'h01);
    load(9'h101, 8'hBB);
    rd(9'h100, r); check("R7 toggle restarts at 0", r, 8'h00);
    wait_idle();
    rd(9'h101, r); check("R8 late load dropped", r, 8'h00);
    rd(9'h100, r); check("R2 byte committed", r, 8'hAA);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule